// File: doc/BRIEF.md
# Shift and Sign-Extend Unit

This block is the shift slice of a 32-bit integer datapath. It takes an operand, a shift amount, an operation code and the carry flag as it stands now. It returns a result word, a new carry value and a strobe that tells the flag register whether to take that value. The design registers every output, so a result appears one clock after the operation is presented with `in_valid` high.

The block has three groups of operations. The barrel shifts move the operand by 0 to 31 places: logical right with zero fill, arithmetic right with sign fill, or left with zero fill. The amount comes from a register operand or from an immediate field, and only the low five bits of either are used. The single-place right shifts always drop operand bit 0 into the carry flag. They differ in what enters bit 31: a copy of the old sign, zero, or the carry flag as it was before the operation. The two sign extensions widen a byte or a halfword to a full word.

Top module: `shu_core`

## Requirements
- R1: While `rst` is high and after it falls, until the first accepted operation, `result`, `carry_out`, `carry_we` and `out_valid` are all zero.
- R2: Op code 0 (barrel logical right) returns the operand shifted right by the amount, with zeros filling from bit 31.
- R3: Op code 1 (barrel arithmetic right) returns the operand shifted right by the amount, with copies of operand bit 31 filling from the top.
- R4: Op code 2 (barrel left) returns the operand shifted left by the amount, with zeros filling from bit 0.
- R5: When `use_imm` is 0, the barrel shift amount is `amt_reg[4:0]`. Bits 31:5 of `amt_reg` and all of `amt_imm` have no effect.
- R6: When `use_imm` is 1, the barrel shift amount is `amt_imm[4:0]`. Bits 15:5 of `amt_imm` and all of `amt_reg` have no effect.
- R7: Op code 3 (one-place arithmetic right) returns {a[31], a[31:1]} and sets the new carry to a[0].
- R8: Op code 4 (one-place logical right) returns {1'b0, a[31:1]} and sets the new carry to a[0].
- R9: Op code 5 (one-place right through carry) returns {carry_in, a[31:1]} and sets the new carry to a[0].
- R10: Op code 6 returns operand bit 7 copied into bits 31:8, with bits 7:0 unchanged.
- R11: Op code 7 returns operand bit 15 copied into bits 31:16, with bits 15:0 unchanged.
- R12: `carry_we` is high only in the cycle after an accepted op code 3, 4 or 5. Barrel shifts and sign extensions leave it low, and `carry_out` keeps its previous value whenever `carry_we` is low.
- R13: Each output reflects the operation accepted on the previous rising clock edge. When `in_valid` is low, `out_valid` and `carry_we` go low and `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (0 to 7, see R2 to R11) |
| use_imm | input | 1 | Take the barrel shift amount from `amt_imm` instead of `amt_reg` |
| a | input | 32 | Operand |
| amt_reg | input | 32 | Register-form shift amount |
| amt_imm | input | 16 | Immediate-form shift amount |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered new carry value |
| carry_we | output | 1 | Carry flag write strobe |
| out_valid | output | 1 | Result is from an operation accepted last cycle |

## Verification
The hardest thing to see from the ports is that `carry_out` holds its value across operations that do not write the flag. The bench first sets the carry with a one-place shift of an odd operand. It then runs a barrel shift and a sign extension and an idle cycle, and checks that the carry stays 1 while `carry_we` stays low. The masking of the shift amount is reached by giving amounts whose upper bits are set, such as 36 through the register form and 0xFFE3 through the immediate form. Each time, the field the form does not use is filled with a value that would give a different result if it were taken.

// File: rtl/shu_pkg.sv
package shu_pkg;
  typedef enum logic [2:0] {
    OP_BSHR_L = 3'd0,
    OP_BSHR_A = 3'd1,
    OP_BSHL   = 3'd2,
    OP_SR1_A  = 3'd3,
    OP_SR1_L  = 3'd4,
    OP_SR1_C  = 3'd5,
    OP_SEXT_B = 3'd6,
    OP_SEXT_H = 3'd7
  } shu_op_e;

  typedef enum logic [1:0] {
    FILL_SIGN  = 2'd0,
    FILL_ZERO  = 2'd1,
    FILL_CARRY = 2'd2
  } shu_fill_e;
endpackage

// File: rtl/shu_barrel.sv
module shu_barrel #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stage [0:SW];
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign rev_in[i] = din[W-1-i];
  end

  assign stage[0] = left ? rev_in : din;
  assign fill     = arith & ~left & din[W-1];

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    always_comb begin
      if (amt[s]) stage[s+1] = {{STEP{fill}}, stage[s][W-1:STEP]};
      else        stage[s+1] = stage[s];
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign rev_out[i] = stage[SW][W-1-i];
  end

  assign dout = left ? rev_out : stage[SW];
endmodule

// File: rtl/shu_onebit.sv
module shu_onebit
  import shu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         cin,
  input  shu_fill_e    fill_sel,
  output logic [W-1:0] dout,
  output logic         cout
);
  logic top_bit;

  always_comb begin
    unique case (fill_sel)
      FILL_SIGN:  top_bit = din[W-1];
      FILL_CARRY: top_bit = cin;
      default:    top_bit = 1'b0;
    endcase
  end

  assign dout = {top_bit, din[W-1:1]};
  assign cout = din[0];
endmodule

// File: rtl/shu_sext.sv
module shu_sext #(
  parameter int W  = 32,
  parameter int BW = 8,
  parameter int HW = 16
) (
  input  logic [W-1:0] din,
  input  logic         half,
  output logic [W-1:0] dout
);
  logic [W-1:0] ext_b;
  logic [W-1:0] ext_h;

  assign ext_b = {{(W-BW){din[BW-1]}}, din[BW-1:0]};
  assign ext_h = {{(W-HW){din[HW-1]}}, din[HW-1:0]};
  assign dout  = half ? ext_h : ext_b;
endmodule

// File: rtl/shu_core.sv
module shu_core
  import shu_pkg::*;
#(
  parameter int W   = 32,
  parameter int IMW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     op,
  input  logic           use_imm,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   amt_reg,
  input  logic [IMW-1:0] amt_imm,
  input  logic           carry_in,
  output logic [W-1:0]   result,
  output logic           carry_out,
  output logic           carry_we,
  output logic           out_valid
);
  localparam int SW = $clog2(W);

  shu_op_e      op_e;
  logic [SW-1:0] amt;
  logic [W-1:0] bar_q;
  logic [W-1:0] one_q;
  logic [W-1:0] ext_q;
  logic         one_c;
  shu_fill_e    fill_sel;
  logic         is_onebit;
  logic [W-1:0] res_d;
  logic         unused_amt;

  assign op_e       = shu_op_e'(op);
  assign amt        = use_imm ? amt_imm[SW-1:0] : amt_reg[SW-1:0];
  assign unused_amt = ^{amt_reg[W-1:SW], amt_imm[IMW-1:SW]};

  shu_barrel #(.W(W), .SW(SW)) u_barrel (
    .din  (a),
    .amt  (amt),
    .left (op_e == OP_BSHL),
    .arith(op_e == OP_BSHR_A),
    .dout (bar_q)
  );

  always_comb begin
    unique case (op_e)
      OP_SR1_A: fill_sel = FILL_SIGN;
      OP_SR1_C: fill_sel = FILL_CARRY;
      default:  fill_sel = FILL_ZERO;
    endcase
  end

  shu_onebit #(.W(W)) u_onebit (
    .din     (a),
    .cin     (carry_in),
    .fill_sel(fill_sel),
    .dout    (one_q),
    .cout    (one_c)
  );

  shu_sext #(.W(W)) u_sext (
    .din (a),
    .half(op_e == OP_SEXT_H),
    .dout(ext_q)
  );

  assign is_onebit = (op_e == OP_SR1_A) || (op_e == OP_SR1_L) || (op_e == OP_SR1_C);

  always_comb begin
    unique case (op_e)
      OP_BSHR_L, OP_BSHR_A, OP_BSHL: res_d = bar_q;
      OP_SR1_A, OP_SR1_L, OP_SR1_C:  res_d = one_q;
      default:                       res_d = ext_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      carry_we  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      carry_we  <= in_valid & is_onebit;
      if (in_valid) result <= res_d;
      if (in_valid && is_onebit) carry_out <= one_c;
    end
  end
endmodule

// File: rtl/shu_core_chk.sv
module shu_core_chk #(
  parameter int W   = 32,
  parameter int IMW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2:0]     op,
  input logic           use_imm,
  input logic [W-1:0]   a,
  input logic [W-1:0]   amt_reg,
  input logic [IMW-1:0] amt_imm,
  input logic           carry_in,
  input logic [W-1:0]   result,
  input logic           carry_out,
  input logic           carry_we,
  input logic           out_valid
);
  logic unused_chk;
  assign unused_chk = ^{use_imm, amt_reg, amt_imm};

  a_r7_sign_shift: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(op) == 3'd3 && !$past(rst)) |->
      (carry_out == $past(a[0]) && result[W-1] == $past(a[W-1])
       && result[W-2:0] == $past(a[W-1:1])));

  a_r8_zero_top: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(op) == 3'd4 && !$past(rst)) |->
      (result[W-1] == 1'b0 && carry_out == $past(a[0])));

  a_r9_carry_top: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(op) == 3'd5 && !$past(rst)) |->
      (result[W-1] == $past(carry_in) && carry_out == $past(a[0])));

  a_r10_byte_ext: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(op) == 3'd6 && !$past(rst)) |->
      (result[W-1:8] == {(W-8){result[7]}}));

  a_r11_half_ext: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(op) == 3'd7 && !$past(rst)) |->
      (result[W-1:16] == {(W-16){result[15]}}));

  a_r12_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
    carry_we |-> out_valid);

  a_r12_carry_held: assert property (@(posedge clk) disable iff (rst)
    (!carry_we && !$past(rst)) |-> $stable(carry_out));

  a_r13_result_held: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(result));
endmodule

bind shu_core shu_core_chk #(.W(W), .IMW(IMW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op       (op),
  .use_imm  (use_imm),
  .a        (a),
  .amt_reg  (amt_reg),
  .amt_imm  (amt_imm),
  .carry_in (carry_in),
  .result   (result),
  .carry_out(carry_out),
  .carry_we (carry_we),
  .out_valid(out_valid)
);

// File: tb/shu_core_bench.sv
module shu_core_bench;
  localparam int N = 17;
  // {op, use_imm, a, amt_reg, amt_imm, carry_in, exp_result, exp_we, exp_carry}
  localparam logic [118:0] TBL [0:N-1] = '{
    {3'd0, 1'b0, 32'hF0000000, 32'd4,        16'hFFFF, 1'b0, 32'h0F000000, 1'b0, 1'b0}, // R2
    {3'd1, 1'b0, 32'hF0000000, 32'd4,        16'hFFFF, 1'b0, 32'hFF000000, 1'b0, 1'b0}, // R3
    {3'd1, 1'b0, 32'h70000000, 32'd4,        16'hFFFF, 1'b0, 32'h07000000, 1'b0, 1'b0}, // R3
    {3'd2, 1'b0, 32'h000000FF, 32'd8,        16'hFFFF, 1'b0, 32'h0000FF00, 1'b0, 1'b0}, // R4
    {3'd0, 1'b0, 32'h80000000, 32'h00000024, 16'h0001, 1'b0, 32'h08000000, 1'b0, 1'b0}, // R5
    {3'd2, 1'b1, 32'h00000001, 32'h00000000, 16'hFFE3, 1'b0, 32'h00000008, 1'b0, 1'b0}, // R6
    {3'd1, 1'b1, 32'h80000000, 32'h00000002, 16'h001F, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R6
    {3'd0, 1'b0, 32'h80000000, 32'd31,       16'h0000, 1'b0, 32'h00000001, 1'b0, 1'b0}, // R2
    {3'd2, 1'b0, 32'h12345678, 32'd0,        16'h0007, 1'b0, 32'h12345678, 1'b0, 1'b0}, // R4
    {3'd3, 1'b0, 32'h80000003, 32'd0,        16'h0000, 1'b0, 32'hC0000001, 1'b1, 1'b1}, // R7
    {3'd4, 1'b0, 32'h80000002, 32'd0,        16'h0000, 1'b1, 32'h40000001, 1'b1, 1'b0}, // R8
    {3'd5, 1'b0, 32'h00000004, 32'd0,        16'h0000, 1'b1, 32'h80000002, 1'b1, 1'b0}, // R9
    {3'd5, 1'b0, 32'hFFFFFFFF, 32'd0,        16'h0000, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b1}, // R9
    {3'd6, 1'b0, 32'h12345680, 32'd0,        16'h0000, 1'b0, 32'hFFFFFF80, 1'b0, 1'b0}, // R10
    {3'd6, 1'b0, 32'hFFFFFF7F, 32'd0,        16'h0000, 1'b0, 32'h0000007F, 1'b0, 1'b0}, // R10
    {3'd7, 1'b0, 32'h00008001, 32'd0,        16'h0000, 1'b0, 32'hFFFF8001, 1'b0, 1'b0}, // R11
    {3'd7, 1'b0, 32'hABCD7FFF, 32'd0,        16'h0000, 1'b0, 32'h00007FFF, 1'b0, 1'b0}  // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] amt_reg = '0;
  logic [15:0] amt_imm = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        carry_we;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shu_core u_shu_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .a(a), .amt_reg(amt_reg), .amt_imm(amt_imm), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .carry_we(carry_we), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic imm, input logic [31:0] av,
                       input logic [31:0] ar, input logic [15:0] ai, input logic ci);
    @(negedge clk);
    in_valid = 1'b1; op = o; use_imm = imm; a = av; amt_reg = ar; amt_imm = ai; carry_in = ci;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 result in reset", result, 32'h0);
    chk("R1 flags in reset", {29'd0, carry_out, carry_we, out_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", {29'd0, carry_out, carry_we, out_valid}, 32'h0);

    for (int i = 0; i < N; i++) begin
      logic [118:0] v;
      v = TBL[i];
      issue(v[118:116], v[115], v[114:83], v[82:51], v[50:35], v[34]);
      chk($sformatf("R2-table vec %0d result", i), result, v[33:2]);
      chk($sformatf("R12 vec %0d carry_we", i), {31'd0, carry_we}, {31'd0, v[1]});
      if (v[1]) chk($sformatf("R7 vec %0d carry", i), {31'd0, carry_out}, {31'd0, v[0]});
      chk("R13 out_valid", {31'd0, out_valid}, 32'd1);
    end

    // R12: set carry, then operations that must not touch it
    issue(3'd4, 1'b0, 32'h00000001, 32'd0, 16'd0, 1'b0);
    chk("R8 carry set to bit0", {31'd0, carry_out}, 32'd1);
    issue(3'd0, 1'b0, 32'h00000010, 32'd1, 16'd0, 1'b0);
    chk("R12 barrel keeps carry", {30'd0, carry_out, carry_we}, 32'd2);
    chk("R2 result", result, 32'h00000008);
    issue(3'd6, 1'b0, 32'h00000001, 32'd0, 16'd0, 1'b0);
    chk("R12 sext keeps carry", {30'd0, carry_out, carry_we}, 32'd2);

    // R13: idle cycle holds result, drops strobes
    @(negedge clk);
    chk("R13 idle result held", result, 32'h00000001);
    chk("R13 idle strobes", {29'd0, carry_out, carry_we, out_valid}, 32'd4);

    // R9 with carry_in 1 on odd operand
    issue(3'd5, 1'b0, 32'h00000003, 32'd0, 16'd0, 1'b1);
    chk("R9 result", result, 32'h80000001);
    chk("R9 carry", {31'd0, carry_out}, 32'd1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid-run reset result", result, 32'h0);
    chk("R1 mid-run reset flags", {29'd0, carry_out, carry_we, out_valid}, 32'h0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule